// File: doc/BRIEF.md
# Pipeline Stage Error Calibration and Correction Engine

This block is the digital back end of a pipelined converter whose front end has four multi-bit stages, each giving 3 raw bits with one bit of overlap, and a 5-bit final flash, for a 17-bit raw word. The three leading stages carry errors in their multiplying stages that exceed the final resolution. The engine measures those errors once, stores one correction term for each stage code, and applies the terms to every later sample. The extra raw bits give those corrections finer steps than the output, and are dropped at the end.

Calibration is bootstrapped from the back of the pipeline. A start pulse makes the engine walk stage 3, then stage 2, then stage 1, and within each stage codes 0 to 7. Stage 3 goes first because it relies only on stages that are never calibrated. Each earlier stage is then measured with the stages behind it already corrected. For every (stage, code) target the engine accepts 2^N error measurements from the measurement path, averages them with an arithmetic right shift, and writes the result into a 24-entry signed term store. In normal operation each sample carries its raw word and the three codes chosen by stages 1 to 3. The engine adds the three matching terms to the raw word, rounds, saturates, drops 1 or 3 low bits and registers the result.

Top module: `cal_corr_engine`

## Requirements
- R1: While reset is active and after it ends, `cal_busy` and `out_valid` are 0 and `cal_stage` is 0. All 24 correction terms are cleared to zero, so a sample taken before any calibration gives only the rounded raw word.
- R2: A one-cycle `cal_start` pulse while idle raises `cal_busy` on the next cycle. A `cal_start` pulse while `cal_busy` is high is ignored and the walk goes on unchanged.
- R3: While busy, `cal_stage` shows the stage being measured, with value 3, 2 or 1. `cal_code` shows the code, from 0 to 7. The walk covers codes 0 to 7 of stage 3, then of stage 2, then of stage 1. Each code advances only after its last measurement.
- R4: Each target takes exactly 2^N measurements, one per cycle with `meas_valid` high. N is `avg_log2` captured at the start pulse, and any value above 8 counts as 8. The stored term is the sum of the 12-bit signed measurements shifted right arithmetically by N, which is the floor of the mean.
- R5: `cal_busy` stays high through cycles with no measurement. It falls on the cycle after the edge that takes the final measurement of stage 1, code 7.
- R6: `meas_valid` and `meas_err` have no effect while `cal_busy` is low. The stored terms and `cal_busy` stay unchanged.
- R7: A sample with `smp_valid` high and `cal_busy` low gives `out_valid` high on the next cycle only. A sample presented while `cal_busy` is high gives no output.
- R8: The corrected value is V = `smp_raw` + E1[`smp_code1`] + E2[`smp_code2`] + E3[`smp_code3`]. Here Ek is the term stored for stage k.
- R9: With `out_wide` = 1, `out_word` is (V+1) >> 1 on all 16 bits. With `out_wide` = 0, `out_word[13:0]` is (V+4) >> 3 and `out_word[15:14]` is 0.
- R10: The rounded value is clamped to the range 0 to 131071 before the low bits are dropped. A negative sum therefore gives 0, and an overflow gives all ones in the selected width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | One-cycle pulse that starts the calibration walk |
| avg_log2 | input | 4 | Averaging exponent N, captured at start and clamped to 8 |
| meas_valid | input | 1 | A measurement for the current target is present |
| meas_err | input | 12 | Signed error measurement |
| cal_busy | output | 1 | Calibration walk in progress |
| cal_stage | output | 2 | Stage under test (3, 2 or 1; 0 when idle) |
| cal_code | output | 3 | Code under test |
| smp_valid | input | 1 | A conversion sample is present |
| smp_raw | input | 17 | Raw error-corrected word |
| smp_code1 | input | 3 | Code chosen by stage 1 |
| smp_code2 | input | 3 | Code chosen by stage 2 |
| smp_code3 | input | 3 | Code chosen by stage 3 |
| out_wide | input | 1 | 1 selects 16-bit output, 0 selects 14-bit |
| out_valid | output | 1 | Corrected word valid |
| out_word | output | 16 | Corrected, rounded, truncated word |

## Verification
The properties take for granted three things about the inputs. `cal_start` is a single-cycle pulse. `avg_log2` and `out_wide` are sampled only at the edges that matter, the start edge and the sample edge. Measurements carry averages that fit the 12-bit term, so the stage and code ordering rules and the output gating rule hold regardless of data. The bench keeps every measurement within about plus or minus 760 codes. It drives all inputs half a cycle away from the sampling edge and drives `out_wide` together with each sample. Its start pulses last exactly one cycle, including the pulse sent in the middle of a walk.

// File: rtl/cal_corr_pkg.sv
package cal_corr_pkg;
  localparam int RAW_W       = 17;  // raw front-end word
  localparam int ERR_W       = 12;  // signed correction term
  localparam int CODE_W      = 3;   // code bits per calibrated stage
  localparam int N_CAL       = 3;   // calibrated leading stages
  localparam int AVG_MAX     = 8;   // largest averaging exponent
  localparam int SHIFT_W     = 4;   // width of the exponent input
  localparam int OUT_W       = 16;  // output word width
  localparam int DROP_WIDE   = 1;   // low bits dropped for 16-bit output
  localparam int DROP_NARROW = 3;   // low bits dropped for 14-bit output

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/cal_sequencer.sv
module cal_sequencer import cal_corr_pkg::*; #(
  parameter int N_STG       = N_CAL,
  parameter int CODE_BITS   = CODE_W,
  parameter int AVG_LOG_MAX = AVG_MAX,
  parameter int SH_W        = SHIFT_W,
  localparam int STG_W      = $clog2(N_STG + 1),
  localparam int CNT_W      = AVG_LOG_MAX,
  localparam int N_CODES    = 1 << CODE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [SH_W-1:0]      avg_log2_i,
  input  logic                 meas_valid_i,
  output logic                 busy_o,
  output logic [STG_W-1:0]     stage_o,
  output logic [CODE_BITS-1:0] code_o,
  output logic [SH_W-1:0]      shift_o,
  output logic                 take_o,
  output logic                 last_o
);
  seq_state_e           st_q, st_d;
  logic [STG_W-1:0]     stg_q, stg_d;
  logic [CODE_BITS-1:0] code_q, code_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [SH_W-1:0]      sh_q, sh_d;
  logic [CNT_W-1:0]     cnt_tgt;
  logic [SH_W-1:0]      sh_start;
  logic                 code_end, stg_end, reg_en;

  // R4: exponent clamp and per-target sample limit (2^N - 1)
  always_comb begin
    sh_start = (avg_log2_i > SH_W'(AVG_LOG_MAX)) ? SH_W'(AVG_LOG_MAX) : avg_log2_i;
    cnt_tgt  = {CNT_W{1'b1}} >> (SH_W'(AVG_LOG_MAX) - sh_q);
    take_o   = (st_q == SEQ_RUN) && meas_valid_i;  // R6: ignored when idle
    last_o   = take_o && (cnt_q == cnt_tgt);
    code_end = (code_q == CODE_BITS'(N_CODES - 1));
    stg_end  = (stg_q == STG_W'(1));
    reg_en   = take_o || ((st_q == SEQ_IDLE) && start_i);
  end

  // Next state: R2 start, R3 stage 3 -> 2 -> 1 walk, R5 finish
  always_comb begin
    st_d   = st_q;
    stg_d  = stg_q;
    code_d = code_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    case (st_q)
      SEQ_IDLE: begin
        if (start_i) begin
          st_d   = SEQ_RUN;
          stg_d  = STG_W'(N_STG);
          code_d = '0;
          cnt_d  = '0;
          sh_d   = sh_start;
        end
      end
      SEQ_RUN: begin
        if (take_o) begin
          if (last_o) begin
            cnt_d  = '0;
            code_d = code_q + 1'b1;
            if (code_end) begin
              stg_d = stg_q - 1'b1;
              if (stg_end) st_d = SEQ_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      stg_q  <= '0;
      code_q <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else if (reg_en) begin
      st_q   <= st_d;
      stg_q  <= stg_d;
      code_q <= code_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
    end
  end

  assign busy_o  = (st_q == SEQ_RUN);
  assign stage_o = stg_q;
  assign code_o  = code_q;
  assign shift_o = sh_q;
endmodule

// File: rtl/cal_averager.sv
module cal_averager import cal_corr_pkg::*; #(
  parameter int ERR_BITS    = ERR_W,
  parameter int AVG_LOG_MAX = AVG_MAX,
  parameter int SH_W        = SHIFT_W,
  localparam int ACC_W      = ERR_BITS + AVG_LOG_MAX
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take_i,
  input  logic                       last_i,
  input  logic [SH_W-1:0]            shift_i,
  input  logic signed [ERR_BITS-1:0] meas_i,
  output logic signed [ERR_BITS-1:0] avg_o
);
  logic signed [ACC_W-1:0] acc_q, acc_d, acc_sum, meas_ext;

  // R4: running sum, floor mean by arithmetic shift on the final sample
  always_comb begin
    meas_ext = {{AVG_LOG_MAX{meas_i[ERR_BITS-1]}}, meas_i};
    acc_sum  = acc_q + meas_ext;
    avg_o    = ERR_BITS'(acc_sum >>> shift_i);
    acc_d    = last_i ? '0 : acc_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (take_i) acc_q <= acc_d;
  end
endmodule

// File: rtl/cal_err_ram.sv
module cal_err_ram import cal_corr_pkg::*; #(
  parameter int N_STG     = N_CAL,
  parameter int CODE_BITS = CODE_W,
  parameter int ERR_BITS  = ERR_W,
  localparam int STG_W    = $clog2(N_STG + 1),
  localparam int N_CODES  = 1 << CODE_BITS
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en_i,
  input  logic [STG_W-1:0]                    wr_stage_i,
  input  logic [CODE_BITS-1:0]                wr_code_i,
  input  logic [ERR_BITS-1:0]                 wr_data_i,
  input  logic [N_STG-1:0][CODE_BITS-1:0]     rd_code_i,
  output logic [N_STG-1:0][ERR_BITS-1:0]      rd_err_o
);
  // Array index s holds stage s+1; entries clear on reset (R1)
  for (genvar s = 0; s < N_STG; s++) begin : g_stg
    logic [N_CODES-1:0][ERR_BITS-1:0] row;
    for (genvar c = 0; c < N_CODES; c++) begin : g_code
      logic                hit;
      logic [ERR_BITS-1:0] ent_q;
      assign hit = wr_en_i && (wr_stage_i == STG_W'(s + 1))
                           && (wr_code_i == CODE_BITS'(c));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ent_q <= '0;
        else if (hit) ent_q <= wr_data_i;
      end
      assign row[c] = ent_q;
    end
    assign rd_err_o[s] = row[rd_code_i[s]];
  end
endmodule

// File: rtl/corr_datapath.sv
module corr_datapath import cal_corr_pkg::*; #(
  parameter int RAW_BITS = RAW_W,
  parameter int ERR_BITS = ERR_W,
  parameter int N_STG    = N_CAL,
  parameter int OUT_BITS = OUT_W,
  parameter int DROP_W   = DROP_WIDE,
  parameter int DROP_N   = DROP_NARROW,
  localparam int SUM_W   = RAW_BITS + $clog2(N_STG) + 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fire_i,
  input  logic [RAW_BITS-1:0]            raw_i,
  input  logic [N_STG-1:0][ERR_BITS-1:0] err_i,
  input  logic                           wide_i,
  output logic                           vld_o,
  output logic [OUT_BITS-1:0]            word_o
);
  localparam logic [SUM_W-1:0] SAT_HI = {{(SUM_W-RAW_BITS){1'b0}}, {RAW_BITS{1'b1}}};
  localparam logic [SUM_W-1:0] RND_W  = SUM_W'(1) << (DROP_W - 1);
  localparam logic [SUM_W-1:0] RND_N  = SUM_W'(1) << (DROP_N - 1);

  logic [SUM_W-1:0]    sum, tot;
  logic [RAW_BITS-1:0] clip;
  logic [OUT_BITS-1:0] word_d;
  logic                vld_q;
  logic [OUT_BITS-1:0] word_q;

  always_comb begin
    // R8: raw word plus the three selected terms (two's complement)
    sum = {{(SUM_W-RAW_BITS){1'b0}}, raw_i};
    for (int s = 0; s < N_STG; s++) begin
      sum = sum + {{(SUM_W-ERR_BITS){err_i[s][ERR_BITS-1]}}, err_i[s]};
    end
    // R9: round at the first dropped bit
    tot = sum + (wide_i ? RND_W : RND_N);
    // R10: clamp to the raw range before dropping bits
    if (tot[SUM_W-1])      clip = '0;
    else if (tot > SAT_HI) clip = {RAW_BITS{1'b1}};
    else                   clip = tot[RAW_BITS-1:0];
    word_d = wide_i ? OUT_BITS'(clip >> DROP_W) : OUT_BITS'(clip >> DROP_N);
  end

  // R7: one register stage, load only on an accepted sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q <= fire_i;
      if (fire_i) word_q <= word_d;
    end
  end

  assign vld_o  = vld_q;
  assign word_o = word_q;
endmodule

// File: rtl/cal_corr_engine.sv
module cal_corr_engine import cal_corr_pkg::*; #(
  parameter int N_STG       = N_CAL,
  parameter int CODE_BITS   = CODE_W,
  parameter int ERR_BITS    = ERR_W,
  parameter int RAW_BITS    = RAW_W,
  parameter int AVG_LOG_MAX = AVG_MAX,
  parameter int SH_W        = SHIFT_W,
  parameter int OUT_BITS    = OUT_W,
  parameter int DROP_W      = DROP_WIDE,
  parameter int DROP_N      = DROP_NARROW,
  localparam int STG_W      = $clog2(N_STG + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cal_start,
  input  logic [SH_W-1:0]      avg_log2,
  input  logic                 meas_valid,
  input  logic [ERR_BITS-1:0]  meas_err,
  output logic                 cal_busy,
  output logic [STG_W-1:0]     cal_stage,
  output logic [CODE_BITS-1:0] cal_code,
  input  logic                 smp_valid,
  input  logic [RAW_BITS-1:0]  smp_raw,
  input  logic [CODE_BITS-1:0] smp_code1,
  input  logic [CODE_BITS-1:0] smp_code2,
  input  logic [CODE_BITS-1:0] smp_code3,
  input  logic                 out_wide,
  output logic                 out_valid,
  output logic [OUT_BITS-1:0]  out_word
);
  logic                           take, last_smp, fire;
  logic [SH_W-1:0]                shift;
  logic signed [ERR_BITS-1:0]     avg;
  logic [N_STG-1:0][CODE_BITS-1:0] rd_code;
  logic [N_STG-1:0][ERR_BITS-1:0]  rd_err;

  cal_sequencer #(
    .N_STG(N_STG), .CODE_BITS(CODE_BITS), .AVG_LOG_MAX(AVG_LOG_MAX), .SH_W(SH_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(cal_start), .avg_log2_i(avg_log2),
    .meas_valid_i(meas_valid), .busy_o(cal_busy), .stage_o(cal_stage),
    .code_o(cal_code), .shift_o(shift), .take_o(take), .last_o(last_smp)
  );

  cal_averager #(
    .ERR_BITS(ERR_BITS), .AVG_LOG_MAX(AVG_LOG_MAX), .SH_W(SH_W)
  ) u_avg (
    .clk(clk), .rst_n(rst_n), .take_i(take), .last_i(last_smp),
    .shift_i(shift), .meas_i(meas_err), .avg_o(avg)
  );

  // Stage 1 code sits at index 0, stage 3 code at the top
  assign rd_code = {smp_code3, smp_code2, smp_code1};

  cal_err_ram #(
    .N_STG(N_STG), .CODE_BITS(CODE_BITS), .ERR_BITS(ERR_BITS)
  ) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en_i(last_smp), .wr_stage_i(cal_stage),
    .wr_code_i(cal_code), .wr_data_i(avg), .rd_code_i(rd_code), .rd_err_o(rd_err)
  );

  // R7: samples are dropped while the walk runs
  assign fire = smp_valid && !cal_busy;

  corr_datapath #(
    .RAW_BITS(RAW_BITS), .ERR_BITS(ERR_BITS), .N_STG(N_STG), .OUT_BITS(OUT_BITS),
    .DROP_W(DROP_W), .DROP_N(DROP_N)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .raw_i(smp_raw), .err_i(rd_err),
    .wide_i(out_wide), .vld_o(out_valid), .word_o(out_word)
  );
endmodule

// File: rtl/cal_corr_engine_chk.sv
module cal_corr_engine_chk #(
  parameter int STG_W     = 2,
  parameter int CODE_BITS = 3,
  parameter int OUT_BITS  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cal_start,
  input logic                 meas_valid,
  input logic                 cal_busy,
  input logic [STG_W-1:0]     cal_stage,
  input logic [CODE_BITS-1:0] cal_code,
  input logic                 smp_valid,
  input logic                 out_wide,
  input logic                 out_valid,
  input logic [OUT_BITS-1:0]  out_word
);
  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_busy) |-> $past(cal_start));

  assert_stage_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> (cal_stage != '0));

  assert_stage_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && $past(cal_busy) && (cal_stage != $past(cal_stage)))
      |-> (cal_stage == $past(cal_stage) - 1'b1));

  assert_code_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && $past(cal_busy) && (cal_code != $past(cal_code)))
      |-> (cal_code == $past(cal_code) + 1'b1));

  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !meas_valid) |=> cal_busy);

  assert_out_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(smp_valid) && !$past(cal_busy)));

  assert_narrow_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(out_wide)) |-> ((out_word >> (OUT_BITS - 2)) == '0));
endmodule

bind cal_corr_engine cal_corr_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .meas_valid(meas_valid),
  .cal_busy(cal_busy), .cal_stage(cal_stage), .cal_code(cal_code),
  .smp_valid(smp_valid), .out_wide(out_wide), .out_valid(out_valid),
  .out_word(out_word)
);

// File: tb/tb_cal_corr_engine.sv
module tb_cal_corr_engine;
  logic        clk, rst_n;
  logic        cal_start, meas_valid, smp_valid, out_wide;
  logic [3:0]  avg_log2;
  logic [11:0] meas_err;
  logic        cal_busy, out_valid;
  logic [1:0]  cal_stage;
  logic [2:0]  cal_code;
  logic [16:0] smp_raw;
  logic [2:0]  smp_code1, smp_code2, smp_code3;
  logic [15:0] out_word;

  int total = 0;
  int bad   = 0;
  int exp_err [1:3][0:7];

  cal_corr_engine dut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .avg_log2(avg_log2),
    .meas_valid(meas_valid), .meas_err(meas_err), .cal_busy(cal_busy),
    .cal_stage(cal_stage), .cal_code(cal_code), .smp_valid(smp_valid),
    .smp_raw(smp_raw), .smp_code1(smp_code1), .smp_code2(smp_code2),
    .smp_code3(smp_code3), .out_wide(out_wide), .out_valid(out_valid),
    .out_word(out_word)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // Zero-term vectors (after reset): raw, width select, hand-computed result
  localparam int N_VEC = 10;
  localparam int VEC_RAW  [N_VEC] = '{0, 1, 2, 131071, 131071, 100, 3, 4, 77777, 77777};
  localparam int VEC_WIDE [N_VEC] = '{1, 1, 1, 1,      0,      0,   0, 0, 1,     0};
  localparam int VEC_EXP  [N_VEC] = '{0, 1, 1, 65535,  16383,  13,  0, 1, 38889, 9722};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int meas_base(input int s, input int c);
    return (((s * 5 + c * 3) % 11) - 5) * 150;
  endfunction

  function automatic int model(input int raw, input int c1, input int c2,
                               input int c3, input int wide);
    int v;
    v = raw + exp_err[1][c1] + exp_err[2][c2] + exp_err[3][c3];
    v = v + (wide != 0 ? 1 : 4);
    if (v < 0) v = 0;
    if (v > 131071) v = 131071;
    return (wide != 0) ? (v >> 1) : (v >> 3);
  endfunction

  // Drive one sample at a falling edge; result is visible one edge later
  task automatic do_sample(input int raw, input int c1, input int c2,
                           input int c3, input int wide);
    smp_raw   = 17'(raw);
    smp_code1 = 3'(c1);
    smp_code2 = 3'(c2);
    smp_code3 = 3'(c3);
    out_wide  = wide[0];
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic run_cal(input int n_prog, input int n_eff, input int sgn);
    cal_start = 1'b1;
    avg_log2  = 4'(n_prog);
    @(negedge clk);
    cal_start = 1'b0;
    chk("R2 busy after start", int'(cal_busy), 1);
    for (int s = 3; s >= 1; s--) begin
      for (int c = 0; c < 8; c++) begin
        int sum = 0;
        int lim = 1 << n_eff;
        if (c == 4) begin
          @(negedge clk);  // gap with no measurement
          chk("R5 busy holds in gap", int'(cal_busy), 1);
        end
        for (int k = 0; k < lim; k++) begin
          int v;
          v = sgn * meas_base(s, c) + (((k % 4) == 3) ? 0 : -1);
          if (k == 0) begin
            chk("R3 stage order", int'(cal_stage), s);
            chk("R3 code order", int'(cal_code), c);
          end
          if (s == 1 && c == 7 && k == lim - 1)
            chk("R5 busy before final", int'(cal_busy), 1);
          meas_valid = 1'b1;
          meas_err   = 12'(v);
          sum += v;
          if (s == 2 && c == 0 && k == 0) cal_start = 1'b1;  // R2: must be ignored
          if (c == 6 && k == 0) begin
            smp_raw = 17'd1000; out_wide = 1'b1; smp_valid = 1'b1;
          end
          @(negedge clk);
          meas_valid = 1'b0;
          cal_start  = 1'b0;
          if (smp_valid) begin
            smp_valid = 1'b0;
            chk("R7 no output while busy", int'(out_valid), 0);
          end
        end
        exp_err[s][c] = sum >>> n_eff;
      end
    end
    chk("R5 busy low after last entry", int'(cal_busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int neg_code;
    rst_n = 1'b0; cal_start = 1'b0; meas_valid = 1'b0; smp_valid = 1'b0;
    out_wide = 1'b1; avg_log2 = '0; meas_err = '0; smp_raw = '0;
    smp_code1 = '0; smp_code2 = '0; smp_code3 = '0;
    for (int s = 1; s <= 3; s++) for (int c = 0; c < 8; c++) exp_err[s][c] = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(cal_busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(cal_busy), 0);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 stage after reset", int'(cal_stage), 0);

    // Table walk: terms are zero, so only rounding, width and clamp act
    for (int i = 0; i < N_VEC; i++) begin
      do_sample(VEC_RAW[i], i % 8, (i + 2) % 8, (i + 5) % 8, VEC_WIDE[i]);
      chk("R1/R9/R10 table valid", int'(out_valid), 1);
      chk("R1/R9/R10 table word", int'(out_word), VEC_EXP[i]);
    end
    @(negedge clk);
    chk("R7 valid lasts one cycle", int'(out_valid), 0);

    // Calibration with N = 2
    run_cal(2, 2, 1);

    // R6: measurements while idle must change nothing
    for (int k = 0; k < 5; k++) begin
      meas_valid = 1'b1;
      meas_err   = 12'h7FF;
      @(negedge clk);
    end
    meas_valid = 1'b0;
    chk("R6 busy stays low", int'(cal_busy), 0);
    do_sample(40000, 1, 2, 3, 1);
    chk("R6 terms unchanged", int'(out_word), model(40000, 1, 2, 3, 1));

    // R8/R10 sweep over codes, widths and raw extremes
    for (int r = 0; r < 3; r++) begin
      int raw;
      raw = (r == 0) ? 0 : ((r == 1) ? 65000 : 131071);
      for (int c = 0; c < 8; c++) begin
        for (int w = 0; w < 2; w++) begin
          do_sample(raw, c, (c + 3) % 8, (c + 5) % 8, w);
          chk("R8/R10 corrected word", int'(out_word), model(raw, c, (c + 3) % 8, (c + 5) % 8, w));
        end
      end
    end

    // R10: a negative corrected sum clamps to zero
    neg_code = -1;
    for (int c = 0; c < 8; c++)
      if (neg_code < 0 && exp_err[1][c] + exp_err[2][c] + exp_err[3][c] < -8) neg_code = c;
    if (neg_code >= 0) begin
      do_sample(0, neg_code, neg_code, neg_code, 0);
      chk("R10 negative clamps to zero", int'(out_word), 0);
    end

    // R4: exponent 15 acts as 8 (256 measurements per code)
    run_cal(15, 8, -1);
    for (int c = 0; c < 8; c++) begin
      for (int w = 0; w < 2; w++) begin
        do_sample(50000, c, (c + 1) % 8, (c + 6) % 8, w);
        chk("R4 averaged terms", int'(out_word), model(50000, c, (c + 1) % 8, (c + 6) % 8, w));
      end
    end

    // R1: reset in the middle of a walk clears state and terms
    cal_start = 1'b1; avg_log2 = 4'd0;
    @(negedge clk);
    cal_start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      meas_valid = 1'b1; meas_err = 12'd500;
      @(negedge clk);
    end
    meas_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy cleared by reset", int'(cal_busy), 0);
    chk("R1 out_valid cleared by reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_sample(1001, 3, 4, 5, 1);
    chk("R1 terms cleared by reset", int'(out_word), 501);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule